// File: doc/BRIEF.md
# Double-Precision Instruction Legality Decoder

This combinational block inspects one 32-bit instruction word and decides whether it is a legal double-precision floating-point instruction for the current core configuration. It reports a legality flag, a compact operation code, the raw register index fields and the rounding mode the instruction will use. Arithmetic, conversion, sign-injection, min/max, compare, classify and move instructions are recognised.

Two configuration bits control what is legal. One says a dedicated floating-point register file is present. The other says doubles are held in the integer register file. When the dedicated file bit is set it takes precedence, and register-pair mode is off. In register-pair mode on a 32-bit core, each double lives in an aligned pair of integer registers. Every operand slot that carries a double must therefore name an even register. Operand slots that carry integers or singles are exempt from this rule. Instructions that carry a rounding-mode field are also checked against the reserved codes. This check uses the supplied dynamic mode when the field asks for it.

The block sits in a decode stage ahead of issue. It has no state and no clock.

Top module: `dpd_decoder`

## Requirements
- R1: With both `fpr_en_i` and `pair_en_i` low, `legal_o` is 0 for every instruction word; `op_o` still shows the matched operation.
- R2: Major opcodes 1000011, 1000111, 1001011, 1001111 with bits [26:25] = 01 decode as op_o 1, 2, 3, 4 (madd, msub, nmsub, nmadd); rs3 is taken from bits [31:27].
- R3: Major opcode 1010011 with bits [31:25] = 0000001, 0000101, 0001001, 0001101 decodes as op_o 5, 6, 7, 8 (add, sub, mul, div), rounding mode in bits [14:12].
- R4: On opcode 1010011: bits [31:25] = 0101101 with bits [24:20] = 0 is op_o 9 (square root); 0100000 with bits [24:20] = 1 is op_o 10 (double to single); 0100001 with bits [24:20] = 0 is op_o 11 (single to double).
- R5: Bits [31:25] = 1100001 is double-to-integer and 1101001 is integer-to-double, with bits [24:20] = 0, 1, 2, 3 selecting signed 32, unsigned 32, signed 64, unsigned 64 (op_o 12..15 and 16..19 respectively); the 64-bit variants are legal only when `xlen64_i` = 1.
- R6: Bits [31:25] = 0010001 with bits [14:12] = 000/001/010 is sign-inject plain/negated/xor (op_o 20/21/22); 0010101 with 000/001 is min/max (op_o 23/24); 1010001 with 010/001/000 is equal/less-than/less-or-equal (op_o 25/26/27).
- R7: With bits [24:20] = 0: bits [31:25] = 1110001 and [14:12] = 001 is classify (op_o 28), 1110001/000 is move to integer (op_o 29), 1111001/000 is move to FP (op_o 30); both moves are legal only when `fpr_en_i` = 1.
- R8: When `pair_en_i` = 1, `fpr_en_i` = 0 and `xlen64_i` = 0, the instruction is illegal if bit 0 is set in any checked index: rs1, rs2, rs3, rd for op 1..4; rs1, rs2, rd for op 5..8 and 20..24; rs1, rd for op 9; rs1, rs2 for op 25..27; rs1 only for op 10, 12..15, 28; rd only for op 11, 16..19.
- R9: With `xlen64_i` = 1, or with `fpr_en_i` = 1, odd register indices never make an instruction illegal.
- R10: For op 1..19, a rounding-mode field of 101 or 110 makes the instruction illegal.
- R11: For op 1..19, a field of 111 takes the mode from `dyn_rm_i`; then `dyn_rm_i` of 101, 110 or 111 makes the instruction illegal, and otherwise `rm_o` equals `dyn_rm_i`.
- R12: Any word that matches none of the patterns above gives `op_o` = 0 and `legal_o` = 0.
- R13: `rd_o`, `rs1_o`, `rs2_o`, `rs3_o` always carry bits [11:7], [19:15], [24:20], [31:27]; `rm_o` is the resolved mode for op 1..19 and 0 for every other op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| xlen64_i | input | 1 | 1 = 64-bit integer registers, 0 = 32-bit |
| fpr_en_i | input | 1 | Dedicated FP register file present |
| pair_en_i | input | 1 | Doubles held in integer registers |
| dyn_rm_i | input | 3 | Dynamic rounding mode from the control register |
| legal_o | output | 1 | Instruction is a legal double-precision instruction |
| op_o | output | 5 | Operation code, 0 = no match |
| rd_o | output | 5 | Destination index field |
| rs1_o | output | 5 | First source index field |
| rs2_o | output | 5 | Second source index field |
| rs3_o | output | 5 | Third source index field |
| rm_o | output | 3 | Resolved rounding mode |

## Verification
The assertions watch the configuration side of every decision. A legal output never appears without an enable. A move is never legal without the dedicated file. A 64-bit conversion is never legal on a 32-bit core. No checked index in pair mode is ever odd. A legal rounding mode is never reserved, and a static field is passed through unchanged. What they cannot show is that each bit pattern maps to the right operation. The per-class choice of checked slots also needs the bench. It sweeps odd and even indices over every operation in three configurations, and it walks the full field-by-dynamic rounding-mode grid.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int RM_W   = 3;
  localparam int NSLOT  = 4;
  localparam int OPC_W  = 7;

  // slot positions inside a check mask
  localparam int SLOT_RS1 = 0;
  localparam int SLOT_RS2 = 1;
  localparam int SLOT_RS3 = 2;
  localparam int SLOT_RD  = 3;

  localparam logic [NSLOT-1:0] MASK_ALL = 4'b1111;
  localparam logic [NSLOT-1:0] MASK_BIN = 4'b1011;
  localparam logic [NSLOT-1:0] MASK_UN  = 4'b1001;
  localparam logic [NSLOT-1:0] MASK_SRC = 4'b0001;
  localparam logic [NSLOT-1:0] MASK_DST = 4'b1000;
  localparam logic [NSLOT-1:0] MASK_CMP = 4'b0011;

  localparam logic [OPC_W-1:0] OPC_MADD  = 7'b1000011;
  localparam logic [OPC_W-1:0] OPC_MSUB  = 7'b1000111;
  localparam logic [OPC_W-1:0] OPC_NMSUB = 7'b1001011;
  localparam logic [OPC_W-1:0] OPC_NMADD = 7'b1001111;
  localparam logic [OPC_W-1:0] OPC_FP    = 7'b1010011;

  localparam logic [RM_W-1:0] RM_DYN     = 3'b111;
  localparam logic [RM_W-1:0] RM_MAX_OK  = 3'b100;

  typedef enum logic [4:0] {
    OP_NONE, OP_MADD, OP_MSUB, OP_NMSUB, OP_NMADD,
    OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SQRT,
    OP_CVT_S_D, OP_CVT_D_S,
    OP_CVT_W_D, OP_CVT_WU_D, OP_CVT_L_D, OP_CVT_LU_D,
    OP_CVT_D_W, OP_CVT_D_WU, OP_CVT_D_L, OP_CVT_D_LU,
    OP_SGNJ, OP_SGNJN, OP_SGNJX, OP_MIN, OP_MAX,
    OP_FEQ, OP_FLT, OP_FLE, OP_CLASS, OP_MV_X_D, OP_MV_D_X
  } dop_e;

  localparam int OP_W = $bits(dop_e);
endpackage

// File: rtl/dpd_field_decode.sv
module dpd_field_decode
  import dpd_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dop_e              op_o,
  output logic [NSLOT-1:0]  mask_o,
  output logic              uses_rm_o,
  output logic              wide_o,
  output logic              fpr_only_o
);
  logic [OPC_W-1:0] opc;
  logic [6:0]       f7;
  logic [4:0]       f5;
  logic [2:0]       f3;
  logic [1:0]       fmt;

  assign opc = insn_i[6:0];
  assign f7  = insn_i[31:25];
  assign f5  = insn_i[24:20];
  assign f3  = insn_i[14:12];
  assign fmt = insn_i[26:25];

  always_comb begin
    op_o       = OP_NONE;
    mask_o     = '0;
    uses_rm_o  = 1'b0;
    wide_o     = 1'b0;
    fpr_only_o = 1'b0;
    case (opc)
      OPC_MADD, OPC_MSUB, OPC_NMSUB, OPC_NMADD: begin
        if (fmt == 2'b01) begin
          mask_o    = MASK_ALL;
          uses_rm_o = 1'b1;
          case (opc)
            OPC_MADD:  op_o = OP_MADD;
            OPC_MSUB:  op_o = OP_MSUB;
            OPC_NMSUB: op_o = OP_NMSUB;
            default:   op_o = OP_NMADD;
          endcase
        end
      end
      OPC_FP: begin
        case (f7)
          7'b0000001: begin op_o = OP_ADD; mask_o = MASK_BIN; uses_rm_o = 1'b1; end
          7'b0000101: begin op_o = OP_SUB; mask_o = MASK_BIN; uses_rm_o = 1'b1; end
          7'b0001001: begin op_o = OP_MUL; mask_o = MASK_BIN; uses_rm_o = 1'b1; end
          7'b0001101: begin op_o = OP_DIV; mask_o = MASK_BIN; uses_rm_o = 1'b1; end
          7'b0101101:
            if (f5 == 5'd0) begin op_o = OP_SQRT; mask_o = MASK_UN; uses_rm_o = 1'b1; end
          7'b0100000:
            if (f5 == 5'd1) begin op_o = OP_CVT_S_D; mask_o = MASK_SRC; uses_rm_o = 1'b1; end
          7'b0100001:
            if (f5 == 5'd0) begin op_o = OP_CVT_D_S; mask_o = MASK_DST; uses_rm_o = 1'b1; end
          7'b1100001: begin
            if (f5[4:2] == 3'b000) begin
              mask_o    = MASK_SRC;
              uses_rm_o = 1'b1;
              wide_o    = f5[1];
              case (f5[1:0])
                2'd0:    op_o = OP_CVT_W_D;
                2'd1:    op_o = OP_CVT_WU_D;
                2'd2:    op_o = OP_CVT_L_D;
                default: op_o = OP_CVT_LU_D;
              endcase
            end
          end
          7'b1101001: begin
            if (f5[4:2] == 3'b000) begin
              mask_o    = MASK_DST;
              uses_rm_o = 1'b1;
              wide_o    = f5[1];
              case (f5[1:0])
                2'd0:    op_o = OP_CVT_D_W;
                2'd1:    op_o = OP_CVT_D_WU;
                2'd2:    op_o = OP_CVT_D_L;
                default: op_o = OP_CVT_D_LU;
              endcase
            end
          end
          7'b0010001: begin
            mask_o = MASK_BIN;
            case (f3)
              3'b000:  op_o = OP_SGNJ;
              3'b001:  op_o = OP_SGNJN;
              3'b010:  op_o = OP_SGNJX;
              default: mask_o = '0;
            endcase
          end
          7'b0010101: begin
            mask_o = MASK_BIN;
            case (f3)
              3'b000:  op_o = OP_MIN;
              3'b001:  op_o = OP_MAX;
              default: mask_o = '0;
            endcase
          end
          7'b1010001: begin
            mask_o = MASK_CMP;
            case (f3)
              3'b010:  op_o = OP_FEQ;
              3'b001:  op_o = OP_FLT;
              3'b000:  op_o = OP_FLE;
              default: mask_o = '0;
            endcase
          end
          7'b1110001: begin
            if (f5 == 5'd0) begin
              if (f3 == 3'b001) begin
                op_o = OP_CLASS; mask_o = MASK_SRC;
              end else if (f3 == 3'b000) begin
                op_o = OP_MV_X_D; fpr_only_o = 1'b1;
              end
            end
          end
          7'b1111001:
            if (f5 == 5'd0 && f3 == 3'b000) begin
              op_o = OP_MV_D_X; fpr_only_o = 1'b1;
            end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  // a decoded check mask always belongs to a matched operation
  always_comb begin
    if (op_o == OP_NONE)
      p_mask_needs_op_r12: assert (mask_o == '0 && !uses_rm_o && !fpr_only_o)
        else $error("decode side-band set without an operation");
  end
endmodule

// File: rtl/dpd_pair_check.sv
module dpd_pair_check
  import dpd_pkg::*;
#(
  parameter int SLOTS = NSLOT
) (
  input  logic             active_i,
  input  logic [SLOTS-1:0] mask_i,
  input  logic [SLOTS-1:0] lsb_i,
  output logic             odd_hit_o
);
  logic [SLOTS-1:0] hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit[s] = active_i & mask_i[s] & lsb_i[s];
  end

  assign odd_hit_o = |hit;
endmodule

// File: rtl/dpd_rm_check.sv
module dpd_rm_check
  import dpd_pkg::*;
(
  input  logic [RM_W-1:0] field_i,
  input  logic [RM_W-1:0] dyn_i,
  output logic            ok_o,
  output logic [RM_W-1:0] eff_o
);
  logic is_dyn;

  assign is_dyn = (field_i == RM_DYN);
  assign eff_o  = is_dyn ? dyn_i : field_i;
  // reserved codes sit above RM_MAX_OK; dynamic code resolves first
  assign ok_o   = (eff_o <= RM_MAX_OK);
endmodule

// File: rtl/dpd_decoder.sv
module dpd_decoder
  import dpd_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              xlen64_i,
  input  logic              fpr_en_i,
  input  logic              pair_en_i,
  input  logic [RM_W-1:0]   dyn_rm_i,
  output logic              legal_o,
  output logic [OP_W-1:0]   op_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic [IDX_W-1:0]  rs1_o,
  output logic [IDX_W-1:0]  rs2_o,
  output logic [IDX_W-1:0]  rs3_o,
  output logic [RM_W-1:0]   rm_o
);
  dop_e             op;
  logic [NSLOT-1:0] mask;
  logic [NSLOT-1:0] lsb;
  logic             uses_rm, wide, fpr_only;
  logic             pair32, odd_hit;
  logic             rm_ok;
  logic [RM_W-1:0]  rm_eff;
  logic             enabled;

  assign rd_o  = insn_i[11:7];
  assign rs1_o = insn_i[19:15];
  assign rs2_o = insn_i[24:20];
  assign rs3_o = insn_i[31:27];

  dpd_field_decode u_dec (
    .insn_i     (insn_i),
    .op_o       (op),
    .mask_o     (mask),
    .uses_rm_o  (uses_rm),
    .wide_o     (wide),
    .fpr_only_o (fpr_only)
  );

  assign lsb[SLOT_RS1] = rs1_o[0];
  assign lsb[SLOT_RS2] = rs2_o[0];
  assign lsb[SLOT_RS3] = rs3_o[0];
  assign lsb[SLOT_RD]  = rd_o[0];

  // dedicated file wins over pair mode when both are set
  assign pair32 = pair_en_i & ~fpr_en_i & ~xlen64_i;

  dpd_pair_check #(.SLOTS(NSLOT)) u_pair (
    .active_i  (pair32),
    .mask_i    (mask),
    .lsb_i     (lsb),
    .odd_hit_o (odd_hit)
  );

  dpd_rm_check u_rm (
    .field_i (insn_i[14:12]),
    .dyn_i   (dyn_rm_i),
    .ok_o    (rm_ok),
    .eff_o   (rm_eff)
  );

  assign enabled = fpr_en_i | pair_en_i;

  assign legal_o = (op != OP_NONE) & enabled
                 & (~fpr_only | fpr_en_i)
                 & (~wide | xlen64_i)
                 & (~uses_rm | rm_ok)
                 & ~odd_hit;
  assign op_o    = op;
  assign rm_o    = uses_rm ? rm_eff : '0;

  always_comb begin
    if (legal_o)
      p_needs_enable_r1: assert (fpr_en_i || pair_en_i)
        else $error("legal with no double support enabled");
    if (op_o == OP_NONE)
      p_no_match_r12: assert (!legal_o)
        else $error("legal without a matched pattern");
    if (legal_o && (op == OP_CVT_L_D || op == OP_CVT_LU_D ||
                    op == OP_CVT_D_L || op == OP_CVT_D_LU))
      p_wide_cvt_r5: assert (xlen64_i)
        else $error("64-bit conversion legal on 32-bit core");
    if (legal_o && (op == OP_MV_X_D || op == OP_MV_D_X))
      p_move_file_r7: assert (fpr_en_i)
        else $error("move legal without FP file");
    if (legal_o && pair32)
      p_even_pairs_r8: assert (!(mask[SLOT_RS1] && rs1_o[0]) && !(mask[SLOT_RS2] && rs2_o[0]) &&
                               !(mask[SLOT_RS3] && rs3_o[0]) && !(mask[SLOT_RD] && rd_o[0]))
        else $error("odd double index accepted in pair mode");
    if (legal_o && uses_rm)
      p_rm_valid_r10: assert (rm_o <= RM_MAX_OK)
        else $error("reserved rounding mode accepted");
    if (legal_o && uses_rm && insn_i[14:12] != RM_DYN)
      p_static_rm_r11: assert (rm_o == insn_i[14:12])
        else $error("static rounding mode altered");
  end
endmodule

// File: tb/dpd_decoder_test.sv
`timescale 1ns/1ps
module dpd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn;
  logic        x64, fpr, pair;
  logic [2:0]  dyn;
  logic        legal;
  logic [4:0]  op, rd, rs1, rs2, rs3;
  logic [2:0]  rm;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dpd_decoder uut (
    .insn_i(insn), .xlen64_i(x64), .fpr_en_i(fpr), .pair_en_i(pair), .dyn_rm_i(dyn),
    .legal_o(legal), .op_o(op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .rs3_o(rs3), .rm_o(rm)
  );

  function automatic logic [31:0] enc(int o, logic [4:0] a1, logic [4:0] a2,
                                      logic [4:0] a3, logic [4:0] d, logic [2:0] r);
    logic [6:0] f7 = 7'd0;
    logic [4:0] r2 = a2;
    logic [2:0] f3 = r;
    case (o)
      1: return {a3, 2'b01, a2, a1, r, d, 7'b1000011};
      2: return {a3, 2'b01, a2, a1, r, d, 7'b1000111};
      3: return {a3, 2'b01, a2, a1, r, d, 7'b1001011};
      4: return {a3, 2'b01, a2, a1, r, d, 7'b1001111};
      5: f7 = 7'b0000001;
      6: f7 = 7'b0000101;
      7: f7 = 7'b0001001;
      8: f7 = 7'b0001101;
      9: begin f7 = 7'b0101101; r2 = 5'd0; end
      10: begin f7 = 7'b0100000; r2 = 5'd1; end
      11: begin f7 = 7'b0100001; r2 = 5'd0; end
      12, 13, 14, 15: begin f7 = 7'b1100001; r2 = 5'(o - 12); end
      16, 17, 18, 19: begin f7 = 7'b1101001; r2 = 5'(o - 16); end
      20, 21, 22: begin f7 = 7'b0010001; f3 = 3'(o - 20); end
      23, 24: begin f7 = 7'b0010101; f3 = 3'(o - 23); end
      25: begin f7 = 7'b1010001; f3 = 3'b010; end
      26: begin f7 = 7'b1010001; f3 = 3'b001; end
      27: begin f7 = 7'b1010001; f3 = 3'b000; end
      28: begin f7 = 7'b1110001; r2 = 5'd0; f3 = 3'b001; end
      29: begin f7 = 7'b1110001; r2 = 5'd0; f3 = 3'b000; end
      30: begin f7 = 7'b1111001; r2 = 5'd0; f3 = 3'b000; end
      default: ;
    endcase
    return {f7, r2, a1, f3, d, 7'b1010011};
  endfunction

  // checked slots per R8, bit order {rd, rs3, rs2, rs1}
  function automatic logic [3:0] chk_mask(int o);
    if (o >= 1 && o <= 4) return 4'b1111;
    if ((o >= 5 && o <= 8) || (o >= 20 && o <= 24)) return 4'b1011;
    if (o == 9) return 4'b1001;
    if (o == 10 || (o >= 12 && o <= 15) || o == 28) return 4'b0001;
    if (o == 11 || (o >= 16 && o <= 19)) return 4'b1000;
    if (o >= 25 && o <= 27) return 4'b0011;
    return 4'b0000;
  endfunction

  // index fields that are free registers in the encoding
  function automatic logic [3:0] free_mask(int o);
    if (o >= 1 && o <= 4) return 4'b1111;
    if ((o >= 5 && o <= 8) || (o >= 20 && o <= 27)) return 4'b1011;
    return 4'b1001;
  endfunction

  function automatic logic exp_legal(int o, logic f, logic p, logic w,
                                     logic [3:0] odd, logic [2:0] r, logic [2:0] dr);
    logic ok = f | p;
    if (p && !f && !w && |(odd & chk_mask(o))) ok = 1'b0;   // R8
    if (o >= 29 && !f) ok = 1'b0;                          // R7
    if ((o == 14 || o == 15 || o == 18 || o == 19) && !w) ok = 1'b0; // R5
    if (o <= 19 && (r == 3'd5 || r == 3'd6 || (r == 3'd7 && dr > 3'd4))) ok = 1'b0; // R10 R11
    return ok;
  endfunction

  task automatic drive(logic [31:0] i, logic f, logic p, logic w, logic [2:0] dr);
    @(posedge clk);
    #1;
    insn = i; fpr = f; pair = p; x64 = w; dyn = dr;
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_idle;
    drive(32'd0, 1'b0, 1'b0, 1'b0, 3'd0);
    chk("R12 idle legal", int'(legal), 0);
    chk("R12 idle op", int'(op), 0);
  endtask

  task automatic t_disabled;
    for (int o = 1; o <= 30; o++) begin
      drive(enc(o, 5'd2, 5'd4, 5'd6, 5'd8, 3'd0), 1'b0, 1'b0, 1'b1, 3'd0);
      chk("R1 disabled legal", int'(legal), 0);
      chk("R1 disabled op", int'(op), o);
    end
  endtask

  task automatic t_all_ops;
    for (int o = 1; o <= 30; o++) begin
      drive(enc(o, 5'd3, 5'd5, 5'd7, 5'd9, 3'd1), 1'b1, 1'b0, 1'b1, 3'd0);
      chk("R2 R3 R4 R6 op", int'(op), o);
      chk("R2 R3 R4 R6 legal", int'(legal), 1);
    end
  endtask

  task automatic t_cvt_width;
    for (int o = 12; o <= 19; o++) begin
      drive(enc(o, 5'd2, 5'd0, 5'd0, 5'd4, 3'd0), 1'b1, 1'b0, 1'b0, 3'd0);
      chk("R5 xlen32 legal", int'(legal), (o == 14 || o == 15 || o == 18 || o == 19) ? 0 : 1);
      chk("R5 op", int'(op), o);
    end
  endtask

  task automatic t_moves;
    for (int o = 29; o <= 30; o++) begin
      drive(enc(o, 5'd2, 5'd0, 5'd0, 5'd4, 3'd0), 1'b1, 1'b0, 1'b0, 3'd0);
      chk("R7 move fpr legal", int'(legal), 1);
      drive(enc(o, 5'd2, 5'd0, 5'd0, 5'd4, 3'd0), 1'b0, 1'b1, 1'b1, 3'd0);
      chk("R7 move pair legal", int'(legal), 0);
      chk("R7 move op", int'(op), o);
    end
    drive(enc(28, 5'd2, 5'd0, 5'd0, 5'd4, 3'd0), 1'b0, 1'b1, 1'b1, 3'd0);
    chk("R7 classify pair legal", int'(legal), 1);
  endtask

  // cfg 0: pair/XLEN32, 1: pair/XLEN64, 2: FP file only
  task automatic t_pair_sweep;
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int o = 1; o <= 30; o++) begin
        for (int c = 0; c < 16; c++) begin
          logic [3:0] odd = 4'(c);
          logic f = (cfg == 2);
          logic p = (cfg != 2);
          logic w = (cfg == 1);
          if ((odd & ~free_mask(o)) != 4'b0000) continue;
          drive(enc(o, 5'(4 + int'(odd[0])), 5'(8 + int'(odd[1])),
                    5'(12 + int'(odd[2])), 5'(16 + int'(odd[3])), 3'd0), f, p, w, 3'd0);
          chk(cfg == 0 ? "R8 pair32 legal" : "R9 no pair check legal",
              int'(legal), int'(exp_legal(o, f, p, w, odd, 3'd0, 3'd0)));
          chk("R8 sweep op", int'(op), o);
        end
      end
    end
  endtask

  task automatic t_rm;
    for (int r = 0; r < 8; r++) begin
      for (int d = 0; d < 8; d++) begin
        drive(enc(5, 5'd2, 5'd4, 5'd0, 5'd6, 3'(r)), 1'b1, 1'b0, 1'b0, 3'(d));
        chk(r == 7 ? "R11 dyn legal" : "R10 field legal", int'(legal),
            int'(exp_legal(5, 1'b1, 1'b0, 1'b0, 4'b0, 3'(r), 3'(d))));
        if (legal) chk("R11 rm_o", int'(rm), r == 7 ? d : r);
      end
    end
  endtask

  task automatic t_unmatched;
    logic [31:0] bad [5];
    bad[0] = {5'd1, 2'b00, 5'd2, 5'd3, 3'd0, 5'd4, 7'b1000011}; // single-format fma
    bad[1] = {7'b0000000, 5'd2, 5'd3, 3'd0, 5'd4, 7'b1010011};   // single add
    bad[2] = {7'b0101101, 5'd1, 5'd3, 3'd0, 5'd4, 7'b1010011};   // sqrt, rs2 != 0
    bad[3] = {7'b1100001, 5'd4, 5'd3, 3'd0, 5'd4, 7'b1010011};   // cvt, rs2 = 4
    bad[4] = {7'b1110001, 5'd0, 5'd3, 3'b010, 5'd4, 7'b1010011}; // classify f3
    for (int k = 0; k < 5; k++) begin
      drive(bad[k], 1'b1, 1'b0, 1'b1, 3'd0);
      chk("R12 unmatched op", int'(op), 0);
      chk("R12 unmatched legal", int'(legal), 0);
    end
  endtask

  task automatic t_fields;
    drive(enc(1, 5'd19, 5'd21, 5'd27, 5'd11, 3'd3), 1'b1, 1'b0, 1'b1, 3'd0);
    chk("R13 rd", int'(rd), 11);
    chk("R13 rs1", int'(rs1), 19);
    chk("R13 rs2", int'(rs2), 21);
    chk("R13 rs3", int'(rs3), 27);
    chk("R13 rm", int'(rm), 3);
    drive(enc(20, 5'd1, 5'd2, 5'd0, 5'd3, 3'd0), 1'b1, 1'b0, 1'b1, 3'd2);
    chk("R13 rm non-rounding op", int'(rm), 0);
  endtask

  initial begin
    insn = '0; fpr = 1'b0; pair = 1'b0; x64 = 1'b0; dyn = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_disabled();
    t_all_ops();
    t_cvt_width();
    t_moves();
    t_pair_sweep();
    t_rm();
    t_unmatched();
    t_fields();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule